// File: doc/BRIEF.md
# Latch-Loop Accumulator Datapath

This block is a small accumulating adder. An external operand `a_in` and the contents of storage register B feed a ripple-carry adder. Storage register C takes the adder result. C can be copied back into B, so that a chain of additions builds up a running sum. B and C are level-sensitive latches in a closed loop: B feeds the adder, the adder feeds C, and C feeds B. Each latch is transparent only during its own enable pulse.

A command port drives the datapath. A command is one of three actions:
- clear B to zero;
- capture the sum into C;
- copy C into B.

A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. The controller turns each accepted command into one enable pulse that lasts exactly one clock cycle. After the pulse it always inserts one idle cycle, so two latch enables can never be high together. `cmd_ready` stays low during the pulse and the gap. This is the back-pressure rule: a sender must hold `cmd_valid`, the command flags and `a_in` steady until the command is accepted. It must also keep `a_in` steady until `busy` falls.

To load a first operand, clear B, capture A+0 into C, then copy C into B. After that, each further operand is added by presenting it on `a_in` and issuing one capture into C.

Top module: `accum_latch_dp`

## Requirements
- R1: After reset, `b_q` and `c_q` are zero, `busy` is 0 and `cmd_ready` is 1.
- R2: A command is accepted only on a clock edge where `cmd_valid`, `cmd_ready` and at least one command flag are all high. A valid request with no flag set has no effect, and `busy` stays 0.
- R3: An accepted command gives `busy`=1 (and `cmd_ready`=0) for exactly two cycles: the pulse cycle and one idle gap. `cmd_ready` returns to 1 in the third cycle after the accepting edge.
- R4: The B and C latch enables are never high in the same cycle. Every enable pulse is followed by a cycle with no enable high.
- R5: A clear command (`clear_b`) sets every bit of `b_q` to 0 and leaves `c_q` unchanged.
- R6: A load command (`load_c`) sets `c_q` to (`a_in` + `b_q`) mod 2^WIDTH and leaves `b_q` unchanged.
- R7: A transfer command (`xfer_b`) copies `c_q` into `b_q` and leaves `c_q` unchanged.
- R8: When several flags are set together, the priority is clear_b, then load_c, then xfer_b. Only the winning action is performed.
- R9: `carry_out` is the carry out of the most significant bit of `a_in` + `b_q` at every moment.
- R10: Between pulses, `b_q` and `c_q` hold their values whatever `a_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The controller can accept a command |
| clear_b | input | 1 | Command flag: clear B |
| load_c | input | 1 | Command flag: capture the sum into C |
| xfer_b | input | 1 | Command flag: copy C into B |
| a_in | input | WIDTH | External operand |
| busy | output | 1 | An enable pulse or its idle gap is in progress |
| b_q | output | WIDTH | Contents of register B |
| c_q | output | WIDTH | Contents of register C |
| carry_out | output | 1 | Carry out of a_in + b_q |

## Verification
The enable pulse fills the cycle right after the accepting edge, and the latch outputs have settled by the end of that cycle. The bench therefore compares `b_q` and `c_q` with its reference at the falling edge of the following gap cycle, one and a half cycles after acceptance. It checks `busy`/`cmd_ready` at the falling edge inside the pulse and again one cycle later. `carry_out` is combinational, so it is checked at a falling edge after `a_in` changes while the block is idle. `a_in` and the command inputs change only at falling edges.

// File: rtl/accum_pkg.sv
package accum_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_GAP   = 2'd2
  } ctl_state_e;

  typedef enum logic [1:0] {
    ACT_CLR = 2'd0,
    ACT_LDC = 2'd1,
    ACT_XFR = 2'd2
  } action_e;
endpackage

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int WIDTH = 2
) (
  input  logic [WIDTH-1:0] op_x,
  input  logic [WIDTH-1:0] op_y,
  output logic [WIDTH-1:0] sum,
  output logic             carry
);
  logic [WIDTH:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign sum[i]  = op_x[i] ^ op_y[i] ^ cy[i];
    assign cy[i+1] = (op_x[i] & op_y[i]) | (cy[i] & (op_x[i] ^ op_y[i]));
  end

  assign carry = cy[WIDTH];
endmodule

// File: rtl/data_latch.sv
module data_latch #(
  parameter int WIDTH = 2
) (
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_latch begin
    if (!rst_n)   q = '0;
    else if (clr) q = '0;
    else if (en)  q = d;
  end
endmodule

// File: rtl/pulse_ctrl.sv
module pulse_ctrl
  import accum_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic clear_b,
  input  logic load_c,
  input  logic xfer_b,
  output logic cmd_ready,
  output logic busy,
  output logic en_clr,
  output logic en_bld,
  output logic en_c
);
  ctl_state_e state;
  action_e    act;
  logic       accept;

  assign cmd_ready = (state == ST_IDLE);
  assign busy      = !cmd_ready;
  assign accept    = cmd_valid && cmd_ready && (clear_b || load_c || xfer_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      act   <= ACT_CLR;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_PULSE;
          if (clear_b)     act <= ACT_CLR;
          else if (load_c) act <= ACT_LDC;
          else             act <= ACT_XFR;
        end
        ST_PULSE: state <= ST_GAP;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign en_clr = (state == ST_PULSE) && (act == ACT_CLR);
  assign en_c   = (state == ST_PULSE) && (act == ACT_LDC);
  assign en_bld = (state == ST_PULSE) && (act == ACT_XFR);

  // R4
  enables_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({en_clr, en_bld, en_c}) <= 1);

  // R4
  gap_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr || en_bld || en_c) |=> !(en_clr || en_bld || en_c) && busy);

  // R3
  accept_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy ##1 busy ##1 !busy);

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && clear_b) |=> en_clr);
endmodule

// File: rtl/accum_latch_dp.sv
module accum_latch_dp #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             clear_b,
  input  logic             load_c,
  input  logic             xfer_b,
  input  logic [WIDTH-1:0] a_in,
  output logic             busy,
  output logic [WIDTH-1:0] b_q,
  output logic [WIDTH-1:0] c_q,
  output logic             carry_out
);
  logic             en_clr, en_bld, en_c;
  logic [WIDTH-1:0] sum;

  pulse_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .clear_b(clear_b), .load_c(load_c), .xfer_b(xfer_b),
    .cmd_ready(cmd_ready), .busy(busy),
    .en_clr(en_clr), .en_bld(en_bld), .en_c(en_c)
  );

  ripple_adder #(.WIDTH(WIDTH)) u_add (
    .op_x(a_in), .op_y(b_q), .sum(sum), .carry(carry_out)
  );

  data_latch #(.WIDTH(WIDTH)) u_reg_b (
    .rst_n(rst_n), .en(en_bld), .clr(en_clr), .d(c_q), .q(b_q)
  );

  data_latch #(.WIDTH(WIDTH)) u_reg_c (
    .rst_n(rst_n), .en(en_c), .clr(1'b0), .d(sum), .q(c_q)
  );

  // R5
  clear_zeroes_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr |-> (b_q == '0));

  // R10
  c_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_c |-> $stable(c_q));

  // R10
  b_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_clr || en_bld) |-> $stable(b_q));
endmodule

// File: tb/accum_latch_dp_tb.sv
module accum_latch_dp_tb;
  localparam int W = 2;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, clear_b = 1'b0, load_c = 1'b0, xfer_b = 1'b0;
  logic [W-1:0] a_in = '0;
  logic cmd_ready, busy, carry_out;
  logic [W-1:0] b_q, c_q;

  int checks = 0;
  int failures = 0;
  int mb = 0;
  int mc = 0;

  always #2 clk = ~clk;

  accum_latch_dp #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .clear_b(clear_b), .load_c(load_c), .xfer_b(xfer_b), .a_in(a_in),
    .busy(busy), .b_q(b_q), .c_q(c_q), .carry_out(carry_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_sum(input int a, input int b);
    return (a + b) % M;
  endfunction

  function automatic int ref_carry(input int a, input int b);
    return ((a + b) >= M) ? 1 : 0;
  endfunction

  // Issue one command; flags {clr,ld,xf}; a held until idle.
  task automatic issue(input logic c, input logic l, input logic x, input int a);
    string tag;
    @(negedge clk);
    a_in = a[W-1:0];
    clear_b = c; load_c = l; xfer_b = x; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; clear_b = 0; load_c = 0; xfer_b = 0;
    chk("R3 busy in pulse", busy, 1);
    chk("R3 ready low in pulse", cmd_ready, 0);
    if (c)      begin mb = 0; tag = "R5/R8 clear"; end
    else if (l) begin mc = ref_sum(a, mb); tag = "R6/R8 load"; end
    else        begin mb = mc; tag = "R7 xfer"; end
    @(negedge clk);
    chk("R3 busy in gap", busy, 1);
    chk({tag, " b"}, b_q, mb);
    chk({tag, " c"}, c_q, mc);
    @(negedge clk);
    chk("R3 ready after gap", cmd_ready, 1);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    chk("R1 b reset", b_q, 0);
    chk("R1 c reset", c_q, 0);
    chk("R1 busy reset", busy, 0);
    chk("R1 ready reset", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: valid without flags is ignored
    cmd_valid = 1'b1; a_in = 2'd3;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2 no-flag busy", busy, 0);
    chk("R2 no-flag c", c_q, 0);

    // directed: load 3, then add 2 -> wraps to 1
    issue(1, 0, 0, 3);
    issue(0, 1, 0, 3);
    issue(0, 0, 1, 3);
    @(negedge clk); a_in = 2'd2; @(negedge clk);
    chk("R9 carry 2+3", carry_out, 1);
    issue(0, 1, 0, 2);
    chk("R6 wrap value", c_q, 1);
    // R8 priority
    issue(1, 0, 1, 0);
    issue(0, 1, 1, 1);
    // R10: a_in wiggles while idle
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); a_in = i[W-1:0];
      @(negedge clk);
      chk("R10 b hold", b_q, mb);
      chk("R10 c hold", c_q, mc);
      chk("R9 carry", carry_out, ref_carry(i, mb));
    end

    for (int n = 0; n < 300; n++) begin
      int r, a;
      logic c, l, x;
      r = $urandom % 8;
      a = $urandom % M;
      c = r[0]; l = r[1]; x = r[2];
      if (r == 0) x = 1'b1;
      issue(c, l, x, a);
      chk("R9 carry rand", carry_out, ref_carry(a, mb));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule